// File: doc/BRIEF.md
# Main-CPU Bus Decoder with Video Control Latches

This block sits on the 16-bit address bus of an 8-bit main processor. It turns each bus access into one chip select for the memories around the processor: two tile-map RAM halves, sound RAM, object/work RAM, a banked program ROM window and the fixed program ROM. The RAMs and ROMs are outside the block. Only the select decision is made here.

Write accesses to the upper half of the address space also reach a set of write-only control registers that the block holds itself. Two latch groups carry per-layer horizontal and vertical scroll bytes and a small ROM bank number. A single tile graphics bank bit takes its value from an address line, not from the data bus. An 8-bit background colour completes the set. Two further write windows have side effects only: one emits a watchdog kick pulse, and the other acknowledges the per-frame interrupt. The block raises that interrupt on each rising edge of a frame pulse.

The selects are combinational from the current bus inputs. All registers, pulses and the interrupt change on the clock edge that ends the access cycle.

Top module: `bus_decode_ctrl`

## Requirements
- R1: With strobe high, addresses 0x0000-0x1FFF assert `sel_tile_lo` and 0x2000-0x3FFF assert `sel_tile_hi`, for both reads (`rnw`=1) and writes.
- R2: With strobe high, 0x4000-0x43FF asserts only `sel_sound`, and 0x4400-0x5FFF asserts `sel_work`. Sound RAM wins where the two windows overlap.
- R3: With strobe high and `rnw`=1, 0x6000-0x7FFF asserts `sel_rom_bank` and 0x8000-0xFFFF asserts `sel_rom_fixed`. A write to those ranges asserts no select. At most one select is high at any time.
- R4: A write to 0x8000-0x83FF makes `wdog_kick` high for exactly the one cycle after the write edge. It is low otherwise.
- R5: `irq` rises in the cycle after a clock edge that samples `frame_pulse` high when it was low at the previous edge. It stays high until a write to 0x8400-0x87FF clears it. If a rising frame edge and an acknowledge happen in the same cycle, `irq` ends high.
- R6: A write to 0x8800-0x8FFF loads `gfx_bank` with address bit 10. The data bus is ignored.
- R7: A write to 0x9000-0x93FF (group 0, layers 0/1) or 0x9400-0x97FF (group 1, layers 2/3) selects layer {A10,A2}. With A1=0 it loads that layer's X scroll byte. With A1:A0=10 it loads that layer's Y scroll byte. Layer n occupies bits [8n+7:8n] of `scroll_x`/`scroll_y`.
- R8: A write with A1:A0=11 in group 0 loads `rom_bank0` from data bits 1:0. The same write in group 1 loads `rom_bank1`. A2 is ignored for this write.
- R9: A write to 0xC000-0xC3FF loads `bg_color` with the data byte.
- R10: Writes to other parts of 0x8000-0xFFFF (for example 0x9800-0xBFFF and 0xC400-0xFFFF) and all reads leave every register unchanged.
- R11: After reset, all scroll, bank, gfx and colour registers are zero, and `irq` and `wdog_kick` are low.
- R12: With strobe low, no select is asserted and no register, pulse or interrupt clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | CPU address |
| wdata | input | DATA_W | CPU write data |
| rnw | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | Access valid this cycle |
| frame_pulse | input | 1 | Frame timing signal, rising edge raises the interrupt |
| sel_tile_lo | output | 1 | Tile-map RAM, layers 0/1 |
| sel_tile_hi | output | 1 | Tile-map RAM, layers 2/3 |
| sel_sound | output | 1 | Sound RAM |
| sel_work | output | 1 | Object/work RAM |
| sel_rom_bank | output | 1 | Banked program ROM (reads) |
| sel_rom_fixed | output | 1 | Fixed program ROM (reads) |
| scroll_x | output | 4*DATA_W | X scroll (and priority) byte per layer |
| scroll_y | output | 4*DATA_W | Y scroll byte per layer |
| rom_bank0 | output | BANK_W | Bank number, group 0 |
| rom_bank1 | output | BANK_W | Bank number, group 1 |
| gfx_bank | output | 1 | Tile graphics bank bit |
| bg_color | output | DATA_W | Background colour |
| wdog_kick | output | 1 | One-cycle watchdog reset pulse |
| irq | output | 1 | Main interrupt request |

## Verification
The bench builds the block with its default DATA_W of 8 and BANK_W of 2. These match a real 8-bit bus, so every sub-register code and every window boundary in the 16-bit map can be reached. Random accesses are weighted toward the latch and control windows and their edges, so layer and group selection by A2 and A10 is exercised in many combinations. Directed cases cover ignored writes, strobe-low writes, and an acknowledge that coincides with a frame edge.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_TILE_LO,
        RG_TILE_HI,
        RG_SOUND,
        RG_WORK,
        RG_ROM_BANK,
        RG_ROM_FIXED
    } region_e;

    typedef enum logic [2:0] {
        CT_NONE,
        CT_WDOG,
        CT_IRQ_ACK,
        CT_GFX,
        CT_LATCH0,
        CT_LATCH1,
        CT_BGCOL
    } ctl_e;

    // address prefixes (upper 6 bits) of the write-only windows
    localparam logic [5:0] PFX_WDOG   = 6'b100000;
    localparam logic [5:0] PFX_ACK    = 6'b100001;
    localparam logic [4:0] PFX_GFX    = 5'b10001;
    localparam logic [5:0] PFX_LATCH0 = 6'b100100;
    localparam logic [5:0] PFX_LATCH1 = 6'b100101;
    localparam logic [5:0] PFX_BGCOL  = 6'b110000;
    localparam logic [5:0] PFX_SOUND  = 6'b010000;
endpackage

// File: rtl/bdc_region_dec.sv
module bdc_region_dec
    import bdc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              strobe,
    output region_e           region,
    output ctl_e              ctl
);
    always_comb begin
        region = RG_NONE;
        if (strobe) begin
            if (addr[15]) begin
                if (rnw) region = RG_ROM_FIXED;
            end else begin
                unique case (addr[14:13])
                    2'b00: region = RG_TILE_LO;
                    2'b01: region = RG_TILE_HI;
                    2'b10: region = (addr[15:10] == PFX_SOUND) ? RG_SOUND : RG_WORK;
                    default: if (rnw) region = RG_ROM_BANK;
                endcase
            end
        end
    end

    always_comb begin
        ctl = CT_NONE;
        if (strobe && !rnw) begin
            if (addr[15:10] == PFX_WDOG)        ctl = CT_WDOG;
            else if (addr[15:10] == PFX_ACK)    ctl = CT_IRQ_ACK;
            else if (addr[15:11] == PFX_GFX)    ctl = CT_GFX;
            else if (addr[15:10] == PFX_LATCH0) ctl = CT_LATCH0;
            else if (addr[15:10] == PFX_LATCH1) ctl = CT_LATCH1;
            else if (addr[15:10] == PFX_BGCOL)  ctl = CT_BGCOL;
        end
    end
endmodule

// File: rtl/bdc_latch_grp.sv
module bdc_latch_grp #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          sub,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] xs,
    output logic [2*DATA_W-1:0] ys,
    output logic [BANK_W-1:0]   bank
);
    typedef struct packed {
        logic [DATA_W-1:0] x1;
        logic [DATA_W-1:0] x0;
        logic [DATA_W-1:0] y1;
        logic [DATA_W-1:0] y0;
        logic [BANK_W-1:0] bank;
    } grp_t;

    grp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (!sub[1]) begin
                if (sub[2]) st_d.x1 = wdata;
                else        st_d.x0 = wdata;
            end else if (!sub[0]) begin
                if (sub[2]) st_d.y1 = wdata;
                else        st_d.y0 = wdata;
            end else begin
                st_d.bank = wdata[BANK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xs   = {st_q.x1, st_q.x0};
    assign ys   = {st_q.y1, st_q.y0};
    assign bank = st_q.bank;
endmodule

// File: rtl/bdc_sys_ctl.sv
module bdc_sys_ctl
    import bdc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_e              ctl,
    input  logic              a10,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_pulse,
    output logic              wdog_kick,
    output logic              irq,
    output logic              gfx_bank,
    output logic [DATA_W-1:0] bg_color
);
    typedef struct packed {
        logic              wdog;
        logic              irq;
        logic              frame_prev;
        logic              gfx;
        logic [DATA_W-1:0] bg;
    } sys_t;

    sys_t s_d, s_q;

    always_comb begin
        s_d            = s_q;
        s_d.wdog       = (ctl == CT_WDOG);
        s_d.frame_prev = frame_pulse;
        if (ctl == CT_IRQ_ACK)             s_d.irq = 1'b0;
        if (frame_pulse && !s_q.frame_prev) s_d.irq = 1'b1;
        if (ctl == CT_GFX)                 s_d.gfx = a10;
        if (ctl == CT_BGCOL)               s_d.bg  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wdog_kick = s_q.wdog;
    assign irq       = s_q.irq;
    assign gfx_bank  = s_q.gfx;
    assign bg_color  = s_q.bg;
endmodule

// File: rtl/bus_decode_ctrl.sv
module bus_decode_ctrl
    import bdc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     rnw,
    input  logic                     strobe,
    input  logic                     frame_pulse,
    output logic                     sel_tile_lo,
    output logic                     sel_tile_hi,
    output logic                     sel_sound,
    output logic                     sel_work,
    output logic                     sel_rom_bank,
    output logic                     sel_rom_fixed,
    output logic [4*DATA_W-1:0]      scroll_x,
    output logic [4*DATA_W-1:0]      scroll_y,
    output logic [BANK_W-1:0]        rom_bank0,
    output logic [BANK_W-1:0]        rom_bank1,
    output logic                     gfx_bank,
    output logic [DATA_W-1:0]        bg_color,
    output logic                     wdog_kick,
    output logic                     irq
);
    localparam int GROUPS   = 2;
    localparam int GRP_BITS = 2 * DATA_W;

    region_e region;
    ctl_e    ctl;
    logic [BANK_W-1:0] bank_w [GROUPS];

    bdc_region_dec u_dec (
        .addr   (addr),
        .rnw    (rnw),
        .strobe (strobe),
        .region (region),
        .ctl    (ctl)
    );

    assign sel_tile_lo   = (region == RG_TILE_LO);
    assign sel_tile_hi   = (region == RG_TILE_HI);
    assign sel_sound     = (region == RG_SOUND);
    assign sel_work      = (region == RG_WORK);
    assign sel_rom_bank  = (region == RG_ROM_BANK);
    assign sel_rom_fixed = (region == RG_ROM_FIXED);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic wr_en;
        assign wr_en = (ctl == ((g == 0) ? CT_LATCH0 : CT_LATCH1));
        bdc_latch_grp #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .sub   (addr[2:0]),
            .wdata (wdata),
            .xs    (scroll_x[g*GRP_BITS +: GRP_BITS]),
            .ys    (scroll_y[g*GRP_BITS +: GRP_BITS]),
            .bank  (bank_w[g])
        );
    end

    assign rom_bank0 = bank_w[0];
    assign rom_bank1 = bank_w[1];

    bdc_sys_ctl #(.DATA_W(DATA_W)) u_sys (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .a10         (addr[10]),
        .wdata       (wdata),
        .frame_pulse (frame_pulse),
        .wdog_kick   (wdog_kick),
        .irq         (irq),
        .gfx_bank    (gfx_bank),
        .bg_color    (bg_color)
    );
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       addr,
    input logic              rnw,
    input logic              strobe,
    input logic              frame_pulse,
    input logic [5:0]        sels,
    input logic              gfx_bank,
    input logic [DATA_W-1:0] bg_color,
    input logic              wdog_kick,
    input logic              irq
);
    logic wr;
    assign wr = strobe && !rnw;

    // R3: never two selects at once
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sels));

    // R12: strobe low leaves all selects low
    p_idle_nosel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> (sels == 6'd0));

    // R4: kick only follows a write to the watchdog window
    p_kick_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[15:10] == 6'b100000) |=> wdog_kick);
    p_kick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr[15:10] == 6'b100000) |=> !wdog_kick);

    // R5: acknowledge clears when no frame edge, otherwise irq holds
    p_irq_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[15:10] == 6'b100001 && !frame_pulse) |=> !irq);
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr && addr[15:10] == 6'b100001)) |=> irq);

    // R6: graphics bank follows A10 of the write
    p_gfx_a10_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[15:11] == 5'b10001) |=> (gfx_bank == $past(addr[10])));

    // R9 / R10: colour only moves on its own window
    p_bg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr[15:10] == 6'b110000) |=> $stable(bg_color));
endmodule

bind bus_decode_ctrl bdc_checker #(.DATA_W(DATA_W)) i_bdc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .rnw         (rnw),
    .strobe      (strobe),
    .frame_pulse (frame_pulse),
    .sels        ({sel_tile_lo, sel_tile_hi, sel_sound, sel_work, sel_rom_bank, sel_rom_fixed}),
    .gfx_bank    (gfx_bank),
    .bg_color    (bg_color),
    .wdog_kick   (wdog_kick),
    .irq         (irq)
);

// File: tb/test_bus_decode_ctrl.sv
module test_bus_decode_ctrl;
    localparam int DW = 8;
    localparam int BW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic rnw = 1'b1, strobe = 1'b0, frame_pulse = 1'b0;
    logic sel_tile_lo, sel_tile_hi, sel_sound, sel_work, sel_rom_bank, sel_rom_fixed;
    logic [4*DW-1:0] scroll_x, scroll_y;
    logic [BW-1:0] rom_bank0, rom_bank1;
    logic gfx_bank, wdog_kick, irq;
    logic [DW-1:0] bg_color;

    int n_chk = 0, n_bad = 0;

    // reference state
    logic [DW-1:0] m_x [4];
    logic [DW-1:0] m_y [4];
    logic [BW-1:0] m_b0, m_b1;
    logic m_gfx, m_kick, m_irq, m_fprev;
    logic [DW-1:0] m_bg;

    always #2 clk = ~clk;

    bus_decode_ctrl #(.DATA_W(DW), .BANK_W(BW)) i_bus_decode_ctrl (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_sel(input logic [15:0] a, input logic r, input logic s);
        int v = int'(a);
        if (!s)          return 6'b000000;
        if (v < 'h2000)  return 6'b100000;
        if (v < 'h4000)  return 6'b010000;
        if (v < 'h4400)  return 6'b001000;
        if (v < 'h6000)  return 6'b000100;
        if (v < 'h8000)  return r ? 6'b000010 : 6'b000000;
        return r ? 6'b000001 : 6'b000000;
    endfunction

    function automatic string sel_tag(input logic [15:0] a);
        int v = int'(a);
        if (v < 'h4000) return "R1 tile select";
        if (v < 'h6000) return "R2 sound/work select";
        return "R3 rom select";
    endfunction

    function automatic logic [4*DW-1:0] pack4(input logic [DW-1:0] m [4]);
        return {m[3], m[2], m[1], m[0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_x[i] = '0; m_y[i] = '0; end
        m_b0 = '0; m_b1 = '0; m_gfx = 0; m_kick = 0; m_irq = 0; m_fprev = 0; m_bg = '0;
    endtask

    task automatic model_step();
        int v = int'(addr);
        logic w = strobe && !rnw;
        int lyr;
        m_kick = w && v >= 'h8000 && v < 'h8400;
        if (w && v >= 'h8400 && v < 'h8800) m_irq = 0;
        if (frame_pulse && !m_fprev) m_irq = 1;
        m_fprev = frame_pulse;
        if (w && v >= 'h8800 && v < 'h9000) m_gfx = addr[10];
        if (w && v >= 'hC000 && v < 'hC400) m_bg = wdata;
        if (w && v >= 'h9000 && v < 'h9800) begin
            lyr = (v >= 'h9400 ? 2 : 0) + (addr[2] ? 1 : 0);
            if (addr[1] == 1'b0)        m_x[lyr] = wdata;
            else if (addr[0] == 1'b0)   m_y[lyr] = wdata;
            else if (v >= 'h9400)       m_b1 = wdata[BW-1:0];
            else                        m_b0 = wdata[BW-1:0];
        end
    endtask

    task automatic check_regs(input string pfx);
        chk({pfx, " R7 scroll_x"}, scroll_x, pack4(m_x));
        chk({pfx, " R7 scroll_y"}, scroll_y, pack4(m_y));
        chk({pfx, " R8 banks"}, {rom_bank1, rom_bank0}, {m_b1, m_b0});
        chk({pfx, " R6 gfx"}, gfx_bank, m_gfx);
        chk({pfx, " R9 bg"}, bg_color, m_bg);
        chk({pfx, " R4 kick"}, wdog_kick, m_kick);
        chk({pfx, " R5 irq"}, irq, m_irq);
    endtask

    task automatic cyc(input logic [15:0] a, input logic [DW-1:0] d, input logic r,
                       input logic s, input logic f, input string pfx);
        @(negedge clk);
        addr = a; wdata = d; rnw = r; strobe = s; frame_pulse = f;
        #1;
        chk({pfx, " ", sel_tag(a)},
            {sel_tile_lo, sel_tile_hi, sel_sound, sel_work, sel_rom_bank, sel_rom_fixed},
            exp_sel(a, r, s));
        @(posedge clk);
        model_step();
        #1;
        check_regs(pfx);
    endtask

    function automatic logic [15:0] rnd_addr();
        int k = $urandom_range(0, 11);
        case (k)
            0:  return 16'(32'h0000 + $urandom_range(0, 'h3FFF));
            1:  return 16'(32'h4000 + $urandom_range(0, 'h1FFF));
            2:  return 16'(32'h6000 + $urandom_range(0, 'h1FFF));
            3:  return 16'(32'h8000 + $urandom_range(0, 'h03FF));
            4:  return 16'(32'h8400 + $urandom_range(0, 'h03FF));
            5:  return 16'(32'h8800 + $urandom_range(0, 'h07FF));
            6, 7, 8: return 16'(32'h9000 + $urandom_range(0, 'h07FF));
            9:  return 16'(32'hC000 + $urandom_range(0, 'h03FF));
            10: return 16'(32'h43FE + $urandom_range(0, 3));
            default: return 16'($urandom_range(0, 'hFFFF));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R11: reset values
        check_regs("reset R11");
        @(negedge clk) rst_n = 1'b1;

        // directed corners
        cyc(16'h9000, 8'h5A, 0, 1, 0, "dir R7 x layer0");
        cyc(16'h9004, 8'hA5, 0, 1, 0, "dir R7 x layer1");
        cyc(16'h9402, 8'h3C, 0, 1, 0, "dir R7 y layer2");
        cyc(16'h9406, 8'hC3, 0, 1, 0, "dir R7 y layer3");
        cyc(16'h9007, 8'hFE, 0, 1, 0, "dir R8 bank0 A2 set");
        cyc(16'h9403, 8'hFD, 0, 1, 0, "dir R8 bank1");
        cyc(16'h8C00, 8'h00, 0, 1, 0, "dir R6 gfx from A10=1");
        cyc(16'h8800, 8'hFF, 0, 1, 0, "dir R6 gfx from A10=0");
        cyc(16'hC3FF, 8'h77, 0, 1, 0, "dir R9 bg");
        cyc(16'h83FF, 8'h00, 0, 1, 0, "dir R4 kick");
        cyc(16'h0000, 8'h00, 1, 1, 0, "dir R4 kick drop");
        cyc(16'h9800, 8'h11, 0, 1, 0, "dir R10 ignored 9800");
        cyc(16'hA000, 8'h22, 0, 1, 0, "dir R10 ignored A000");
        cyc(16'hC400, 8'h33, 0, 1, 0, "dir R10 ignored C400");
        cyc(16'h9000, 8'h44, 1, 1, 0, "dir R10 read no write");
        cyc(16'hC000, 8'h99, 0, 0, 0, "dir R12 strobe low");
        cyc(16'h4000, 8'h00, 0, 1, 0, "dir R2 sound edge");
        cyc(16'h4400, 8'h00, 0, 1, 0, "dir R2 work edge");
        cyc(16'h6000, 8'h00, 0, 1, 0, "dir R3 rom write");
        cyc(16'h7FFF, 8'h00, 1, 1, 1, "dir R5 frame rise");
        cyc(16'h8400, 8'h00, 0, 0, 1, "dir R12 ack strobe low");
        cyc(16'h8400, 8'h00, 0, 1, 0, "dir R5 ack");
        cyc(16'h8400, 8'h00, 0, 1, 1, "dir R5 ack with rise");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            cyc(rnd_addr(), 8'($urandom), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) < 3), "rnd");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule